// File: doc/BRIEF.md
# Sinc Decimation Data Filter

This block turns the 1-bit output of one sigma-delta modulator into multi-bit samples. Each accepted bit counts as +1 when high and 0 when low. The bits pass through a cascade of integrators at the bit rate, are decimated by a run-time ratio from 1 to 256, and then pass through a cascade of combs at the decimated rate. The filter order is chosen at run time from four shapes: first, second and third order sinc, and a fast-settling variant. The fast variant is the second order response multiplied by (1 + z^-2) at the decimated rate.

A bit is taken only in a cycle in which the bit strobe is high, so the modulator clock and the data rate are the same. The channel runs only while both its own enable and a shared group enable are high. When either enable drops, all filter state is cleared. A sync pulse clears the filter and restarts the decimation phase, so several channels that receive the same pulse produce their samples in step. Each result can be presented as the full 32-bit value, or as a 16-bit value taken from a programmable right shift and clamped at the 16-bit maximum.

Top module: `sinc_decim_filter`

## Requirements
- R1: While reset is asserted, and after it is released, `data_out` is 0 and `data_valid` is 0 until the first result.
- R2: The `order_sel` code selects the response: 0 first order, 1 second order, 2 fast, 3 third order. A high bit weighs 1 and a low bit weighs 0. If every window of OSR consecutive bits holds c ones, the settled result is c for order 0, OSR·c for order 1, 2·OSR·c for order 2 and OSR²·c for order 3.
- R3: The OSR is `osr_m1`+1, from 1 to 256. A bit is consumed only in a cycle with `bit_en` high. Once the filter has settled, exactly one result is produced per OSR consumed bits.
- R4: `data_valid` is high for one cycle, in the cycle that follows the clock edge that consumed the last bit of a window. `data_out` changes only together with `data_valid`.
- R5: After a sync or an enable, no result is produced until N·OSR bits have been consumed, where N is 1, 2, 4 and 3 for codes 0, 1, 2 and 3. The first result comes with the N·OSR-th bit.
- R6: A cycle with `sync_in` high clears all filter state and the decimation phase, discards any bit strobed in that cycle, and produces no result in the following cycle.
- R7: While `filt_en` or `main_en` is low, strobes are ignored, no result is produced, filter state is held cleared and `data_out` keeps its last value.
- R8: With `out_wide` high, `data_out` carries the full 32-bit result.
- R9: With `out_wide` low, `data_out` is the result shifted right by `out_shift` (0 to 31). It is clamped to 65535 if the shifted value exceeds 16 bits, and bits 31:16 are zero.
- R10: Full precision is kept: third order at OSR 256 with every bit high yields exactly 16777216.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | Channel enable |
| main_en | input | 1 | Group enable shared by all channels |
| sync_in | input | 1 | Restart pulse for the decimation phase |
| bit_en | input | 1 | Strobe marking a valid modulator bit |
| bit_in | input | 1 | Modulator bit |
| order_sel | input | 2 | Filter order code |
| osr_m1 | input | 8 | Decimation ratio minus one |
| out_wide | input | 1 | 1: 32-bit result, 0: shifted 16-bit result |
| out_shift | input | 5 | Right shift used in 16-bit mode |
| data_out | output | 32 | Filtered sample |
| data_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
Every result is registered in the same edge that consumes the final bit of its window. The bench therefore drives each strobe at the falling edge and reads `data_valid` and `data_out` 1 ns after the next rising edge. For each consumed bit it predicts whether a result is due, using the bit count since the last sync and the settle count N·OSR, and compares the output at that point. Vectors that leave an idle cycle after each strobe also confirm that `data_valid` has fallen one cycle later. In the sync and enable tests, the restart is checked by counting strobes up to the one that should produce the first result, with no result expected before it.

// File: rtl/sdec_pkg.sv
`timescale 1ns/1ps
package sdec_pkg;

    localparam int MAX_STAGES = 3;

    typedef enum logic [1:0] {
        ORD_SINC1 = 2'd0,
        ORD_SINC2 = 2'd1,
        ORD_FAST  = 2'd2,
        ORD_SINC3 = 2'd3
    } sdec_order_e;

    // integrator stage whose output feeds the combs
    function automatic logic [1:0] tap_of(sdec_order_e o);
        case (o)
            ORD_SINC1: return 2'd0;
            ORD_SINC3: return 2'd2;
            default:   return 2'd1;
        endcase
    endfunction

    // number of comb stages in use
    function automatic logic [1:0] combs_of(sdec_order_e o);
        case (o)
            ORD_SINC1: return 2'd1;
            ORD_SINC3: return 2'd3;
            default:   return 2'd2;
        endcase
    endfunction

    // decimated samples needed before the first settled result
    function automatic logic [2:0] settle_of(sdec_order_e o);
        case (o)
            ORD_SINC1: return 3'd1;
            ORD_SINC2: return 3'd2;
            ORD_FAST:  return 3'd4;
            default:   return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/sdec_integ.sv
`timescale 1ns/1ps
module sdec_integ #(
    parameter int ACC_W  = 32,
    parameter int STAGES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          step,
    input  logic                          bit_in,
    output logic [STAGES-1:0][ACC_W-1:0]  sum_o
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t                    st_d, st_q;
    logic [STAGES-1:0][ACC_W-1:0] upd;

    // each stage adds the freshly updated value of the stage before it
    always_comb begin
        logic [ACC_W-1:0] carry;
        carry = {{(ACC_W-1){1'b0}}, bit_in};
        for (int k = 0; k < STAGES; k++) begin
            upd[k] = st_q.acc[k] + carry;
            carry  = upd[k];
        end
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (step) begin
            st_d.acc = upd;
        end
    end

    assign sum_o = upd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdec_comb.sv
`timescale 1ns/1ps
module sdec_comb #(
    parameter int ACC_W  = 32,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic [1:0]       n_combs,
    input  logic             fast_sel,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
        logic [1:0][ACC_W-1:0]        ext;
    } comb_st_t;

    comb_st_t         st_d, st_q;
    logic [ACC_W-1:0] base;

    always_comb begin
        logic [ACC_W-1:0] stage_in;
        stage_in = din;
        st_d     = st_q;
        for (int k = 0; k < STAGES; k++) begin
            if (k < int'(n_combs)) begin
                st_d.dly[k] = stage_in;
                stage_in    = stage_in - st_q.dly[k];
            end
        end
        base = stage_in;
        // fast shape adds the comb output from two decimated samples back
        dout = fast_sel ? (base + st_q.ext[1]) : base;
        st_d.ext[1] = st_q.ext[0];
        st_d.ext[0] = base;
        if (clr) begin
            st_d = '0;
        end else if (!fire) begin
            st_d = st_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdec_outfmt.sv
`timescale 1ns/1ps
module sdec_outfmt #(
    parameter int ACC_W    = 32,
    parameter int NARROW_W = 16,
    parameter int SHIFT_W  = 5
) (
    input  logic [ACC_W-1:0]   full,
    input  logic               wide,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ACC_W-1:0]   word
);

    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = full >> shift;
        if (wide) begin
            word = full;
        end else if (|shifted[ACC_W-1:NARROW_W]) begin
            word = {{(ACC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin
            word = {{(ACC_W-NARROW_W){1'b0}}, shifted[NARROW_W-1:0]};
        end
    end

endmodule

// File: rtl/sinc_decim_filter.sv
`timescale 1ns/1ps
module sinc_decim_filter
    import sdec_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int OSR_W    = 8,
    parameter int SHIFT_W  = 5,
    parameter int NARROW_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               filt_en,
    input  logic               main_en,
    input  logic               sync_in,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic [1:0]         order_sel,
    input  logic [OSR_W-1:0]   osr_m1,
    input  logic               out_wide,
    input  logic [SHIFT_W-1:0] out_shift,
    output logic [ACC_W-1:0]   data_out,
    output logic               data_valid
);

    localparam int SETTLE_W = 3;

    typedef struct packed {
        logic [OSR_W-1:0]    cnt;
        logic [SETTLE_W-1:0] settle;
        logic [ACC_W-1:0]    data;
        logic                valid;
    } top_st_t;

    top_st_t                          st_d, st_q;
    sdec_order_e                      order;
    logic                             run, clr, step, fire;
    logic [SETTLE_W-1:0]              need;
    logic [MAX_STAGES-1:0][ACC_W-1:0] integ_sum;
    logic [ACC_W-1:0]                 comb_in, comb_out, fmt_word;

    assign order = sdec_order_e'(order_sel);
    assign need  = settle_of(order);
    assign run   = filt_en & main_en;
    assign clr   = ~run | sync_in;
    assign step  = run & ~sync_in & bit_en;
    assign fire  = step & (st_q.cnt == osr_m1);

    sdec_integ #(.ACC_W(ACC_W), .STAGES(MAX_STAGES)) integ_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .step   (step),
        .bit_in (bit_in),
        .sum_o  (integ_sum)
    );

    assign comb_in = integ_sum[tap_of(order)];

    sdec_comb #(.ACC_W(ACC_W), .STAGES(MAX_STAGES)) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .fire     (fire),
        .n_combs  (combs_of(order)),
        .fast_sel (order == ORD_FAST),
        .din      (comb_in),
        .dout     (comb_out)
    );

    sdec_outfmt #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .SHIFT_W(SHIFT_W)) fmt_i (
        .full  (comb_out),
        .wide  (out_wide),
        .shift (out_shift),
        .word  (fmt_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (clr) begin
            st_d.cnt    = '0;
            st_d.settle = '0;
        end else if (step) begin
            if (fire) begin
                st_d.cnt = '0;
                if (st_q.settle < need) begin
                    st_d.settle = st_q.settle + 1'b1;
                end
                if (st_q.settle >= need - 1'b1) begin
                    st_d.valid = 1'b1;
                    st_d.data  = fmt_word;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out   = st_q.data;
    assign data_valid = st_q.valid;

endmodule

// File: rtl/sinc_decim_filter_chk.sv
`timescale 1ns/1ps
module sinc_decim_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        filt_en,
    input logic        main_en,
    input logic        sync_in,
    input logic        bit_en,
    input logic        out_wide,
    input logic [31:0] data_out,
    input logic        data_valid
);

    assert_valid_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(bit_en));

    assert_data_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(data_out));

    assert_sync_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> !data_valid);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(filt_en && main_en) |=> !data_valid);

    assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !$past(out_wide)) |-> (data_out[31:16] == 16'd0));

endmodule

bind sinc_decim_filter sinc_decim_filter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_en    (filt_en),
    .main_en    (main_en),
    .sync_in    (sync_in),
    .bit_en     (bit_en),
    .out_wide   (out_wide),
    .data_out   (data_out),
    .data_valid (data_valid)
);

// File: tb/sinc_decim_filter_tb_top.sv
`timescale 1ns/1ps
module sinc_decim_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filt_en = 1'b1, main_en = 1'b1, sync_in = 1'b0;
    logic        bit_en = 1'b0, bit_in = 1'b0;
    logic [1:0]  order_sel = 2'd0;
    logic [7:0]  osr_m1 = 8'd0;
    logic        out_wide = 1'b1;
    logic [4:0]  out_shift = 5'd0;
    logic [31:0] data_out;
    logic        data_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sinc_decim_filter dut_i (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .main_en(main_en),
        .sync_in(sync_in), .bit_en(bit_en), .bit_in(bit_in),
        .order_sel(order_sel), .osr_m1(osr_m1), .out_wide(out_wide),
        .out_shift(out_shift), .data_out(data_out), .data_valid(data_valid)
    );

    // order, osr, ones, period, wide, shift, idle gap, tag kind
    localparam int NV = 12;
    localparam int VEC [0:NV-1][0:7] = '{
        '{0,  16, 1, 2, 1, 0, 1, 0},
        '{1,  32, 3, 4, 1, 0, 1, 0},
        '{3, 256, 1, 1, 1, 0, 0, 3},
        '{2,  64, 1, 4, 1, 0, 1, 0},
        '{3,  64, 1, 2, 0, 0, 0, 2},
        '{3,  64, 1, 2, 0, 1, 0, 2},
        '{3,  64, 1, 2, 0, 2, 0, 2},
        '{3,  64, 1, 2, 0, 3, 1, 2},
        '{0,   1, 1, 1, 1, 0, 0, 1},
        '{0,   1, 0, 1, 1, 0, 0, 1},
        '{1, 256, 1, 2, 0, 2, 0, 2},
        '{2,   8, 3, 8, 1, 0, 0, 0}
    };

    function automatic string tag_of(int kind);
        case (kind)
            0:       return "R2";
            1:       return "R8";
            2:       return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int need_of(int ord);
        case (ord)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            default: return 3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic en, input logic b, input logic sy);
        @(negedge clk);
        bit_en  = en;
        bit_in  = b;
        sync_in = sy;
        @(posedge clk);
        #1;
    endtask

    task automatic run_case(input int ord, input int osr, input int ones, input int period,
                            input int wide, input int shift, input int gap, input int kind);
        longint c, full, expw;
        int     need;
        order_sel = 2'(ord);
        osr_m1    = 8'(osr - 1);
        out_wide  = 1'(wide);
        out_shift = 5'(shift);
        tick(1'b0, 1'b0, 1'b1);
        check(data_valid == 1'b0, "R6", data_valid, 0);
        need = need_of(ord);
        c    = longint'(osr) * ones / period;
        case (ord)
            0:       full = c;
            1:       full = longint'(osr) * c;
            2:       full = 2 * longint'(osr) * c;
            default: full = longint'(osr) * osr * c;
        endcase
        if (wide != 0) expw = full;
        else begin
            expw = full >> shift;
            if (expw > 65535) expw = 65535;
        end
        for (int n = 0; n < (need + 2) * osr; n++) begin
            bit expv;
            tick(1'b1, 1'((n % period) < ones), 1'b0);
            expv = (((n + 1) % osr) == 0) && ((n + 1) >= need * osr);
            check(data_valid == expv, ((n + 1) < need * osr) ? "R5" : "R3", data_valid, expv);
            if (data_valid && expv)
                check(longint'(data_out) == expw, tag_of(kind), data_out, expw);
            if (gap != 0) begin
                tick(1'b0, 1'b0, 1'b0);
                check(data_valid == 1'b0, "R4", data_valid, 0);
            end
        end
    endtask

    // drive strobes of ones until the first result; it must come at strobe 'expect_at'
    task automatic count_to_first(input int expect_at, input string req, input longint expw);
        int got;
        got = 0;
        for (int n = 1; n <= expect_at + 4; n++) begin
            tick(1'b1, 1'b1, 1'b0);
            if (data_valid && got == 0) begin
                got = n;
                check(longint'(data_out) == expw, req, data_out, expw);
            end
        end
        check(got == expect_at, req, got, expect_at);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(data_out == 32'd0, "R1", data_out, 0);
        check(data_valid == 1'b0, "R1", data_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(data_valid == 1'b0, "R1", data_valid, 0);

        for (int v = 0; v < NV; v++)
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                     VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);

        // R7: channel enable low freezes output, clears state
        run_case(0, 4, 1, 1, 1, 0, 0, 1);
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
        filt_en = 1'b0;
        for (int n = 0; n < 8; n++) begin
            tick(1'b1, 1'b1, 1'b0);
            check(data_valid == 1'b0, "R7", data_valid, 0);
            check(data_out == 32'd4, "R7", data_out, 4);
        end
        filt_en = 1'b1;
        count_to_first(4, "R7", 4);

        // R7: group enable low behaves the same way
        order_sel = 2'd1;
        tick(1'b1, 1'b1, 1'b0);
        main_en = 1'b0;
        for (int n = 0; n < 6; n++) begin
            tick(1'b1, 1'b1, 1'b0);
            check(data_valid == 1'b0, "R7", data_valid, 0);
        end
        main_en = 1'b1;
        count_to_first(8, "R7", 16);

        // R6: sync in the middle of a window, with a strobe in the same cycle
        order_sel = 2'd1;
        osr_m1    = 8'd7;
        tick(1'b0, 1'b0, 1'b1);
        for (int n = 0; n < 5; n++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b1);
        check(data_valid == 1'b0, "R6", data_valid, 0);
        count_to_first(16, "R6", 64);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule